// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block is the byte data path that an SMBus host controller uses for block transfers. Software reaches it through a small byte-wide register port. The bit-level bus engine reaches it through two byte streams: one transmit stream and one receive stream, each with a valid/ready handshake. The engine drives SDA and SCL and handles acknowledgement. This block decides which byte goes out next, where each received byte is stored, and when the transfer is over.

There are two modes, selected by a buffer-enable bit in the auxiliary register.

In buffer mode, software fills or empties an internal store of up to 32 bytes through the block data register. An index steps by one on every access. A read of the control register rewinds the index to zero.

In byte mode, every data byte is exchanged through the byte-done status flag. The bus side stalls until software writes 1 to that flag. On a read, software writes the last-byte marker into the control register before it releases the final byte.

The count register carries the transfer length in both directions. On a read, the first received byte is the count. A count of zero, or a count greater than the store depth, aborts the transfer as failed and stores no data.

Top module: `smbblk_buffer`

## Requirements
- R1: After reset, the status, control, count and auxiliary registers read 0x00, and neither tx_valid nor rx_ready is asserted.
- R2: Bit 0 of the auxiliary register (address 4) is the buffer-enable bit, and it reads back exactly the value last written.
- R3: Any CPU read of the control register (address 1) rewinds the block data index to zero, so the next buffer-mode access of the block data register (address 3) uses entry 0.
- R4: In buffer mode, each access of the block data register moves the index forward by one. The index saturates at the store depth and never wraps. Reads at an index at or beyond the count register value return 0x00.
- R5: A buffer-mode block write is started by writing the control register with bit 7 set and bit 0 clear. The transmit stream then carries the count byte, followed by that many stored bytes in index order. At the end, status bit 1 (done) is set and bit 0 (busy) is clear.
- R6: A buffer-mode block read is started by writing the control register with bits 7 and 0 set. The first received byte is placed in the count register, and the following count bytes are placed in the store from entry 0 upward.
- R7: On a read, a received count of 0 or of more than 32 does four things: it sets status bit 2 (failed), pulses bus_abort, ends the transfer at once with rx_ready low, and leaves every store entry unchanged.
- R8: In byte mode, after every data byte status bit 3 (byte-done) is set. tx_valid and rx_ready then stay low until software writes 1 to that bit.
- R9: A byte-mode write sends the byte that sits in the block data register at start as the first data byte. Each later data byte is the value written to that register before byte-done is cleared.
- R10: In a byte-mode read, software may set control bit 1 (last-byte marker) before clearing byte-done. bus_last then goes high, and the transfer completes after the next byte even if the count has not been reached. The received byte reads back from the block data register.
- R11: Status bits 1 to 3 are cleared by writing 1 to them. Writing 0 leaves them unchanged. Starting a transfer clears all three.
- R12: While busy, a start request is ignored, and the direction bit of the control register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (triggers read side effects) |
| cpu_addr | input | 3 | Register address: 0 status, 1 control, 2 count, 3 block data, 4 auxiliary |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for cpu_addr |
| tx_valid | output | 1 | Byte offered to the bus engine |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Bus engine takes the offered byte |
| rx_valid | input | 1 | Bus engine presents a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a received byte |
| bus_last | output | 1 | Next received byte is the final one |
| bus_abort | output | 1 | One-cycle pulse: bad received count, transfer abandoned |
| busy | output | 1 | Transfer in progress |

## Verification
The bench goes after the index rules. It reads past the count and past the store depth, where a wrapping index would hand back entry 0 instead of zero. It also rewinds the index in the middle of a drain, which a design that misses the control-read side effect would not honour. Bad counts of zero and of 33 are injected. A design that checked only one bound would then accept data, keep busy high, or overwrite the store.

In byte mode the bench holds off the byte-done clear for several cycles. A design that does not stall would give up bytes early. The bench also sets the last-byte marker partway through a read, so a design that waits for the full count would leave busy stuck. A start issued in the middle of a transfer would flip the direction in a design that does not guard it.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;

   typedef logic [7:0] octet_t;

   typedef enum logic [2:0] {
      RA_STAT  = 3'd0,
      RA_CTRL  = 3'd1,
      RA_COUNT = 3'd2,
      RA_BDATA = 3'd3,
      RA_AUX   = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_COUNT,
      SQ_DATA,
      SQ_HOLD
   } seq_state_e;

   // status bit positions
   localparam int ST_BUSY  = 0;
   localparam int ST_DONE  = 1;
   localparam int ST_FAIL  = 2;
   localparam int ST_BDONE = 3;

   // control bit positions
   localparam int CT_READ  = 0;
   localparam int CT_LAST  = 1;
   localparam int CT_START = 7;

   // auxiliary bit positions
   localparam int AX_BUF   = 0;

endpackage

// File: rtl/smbblk_store.sv
module smbblk_store
   import smbblk_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int IW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idx_clr,
   input  logic          idx_step,
   input  logic          cpu_we,
   input  octet_t        cpu_wdata,
   input  octet_t        limit,
   output octet_t        cpu_rdata,
   input  logic [IW-1:0] bus_raddr,
   output octet_t        bus_rdata,
   input  logic          bus_we,
   input  logic [IW-1:0] bus_waddr,
   input  octet_t        bus_wdata
);

   localparam int AW = $clog2(DEPTH);
   localparam logic [IW-1:0] TOP = IW'(DEPTH);

   logic [DEPTH-1:0][7:0] cells;
   logic [IW-1:0]         idx;

   // one register per entry; the bus side wins over the CPU side
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         octet_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (bus_we && bus_waddr == IW'(g))
               q <= bus_wdata;
            else if (cpu_we && idx == IW'(g))
               q <= cpu_wdata;
         end
         assign cells[g] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (idx_clr)
         idx <= '0;
      else if (idx_step && idx != TOP)
         idx <= idx + 1'b1;
   end

   always_comb begin
      cpu_rdata = '0;
      if (idx < TOP && 9'(idx) < 9'(limit))
         cpu_rdata = cells[idx[AW-1:0]];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_raddr < TOP)
         bus_rdata = cells[bus_raddr[AW-1:0]];
   end

   a_r4_idx_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      idx <= TOP);

   a_r3_idx_rewind : assert property (@(posedge clk) disable iff (!rst_n)
      idx_clr |=> idx == '0);

endmodule

// File: rtl/smbblk_seq.sv
module smbblk_seq
   import smbblk_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int IW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          go_read,
   input  logic          go_buf,
   input  octet_t        count,
   input  logic          last_mark,
   input  logic          clr_done,
   input  logic          clr_fail,
   input  logic          clr_bdone,
   output logic          busy,
   output logic          done_f,
   output logic          fail_f,
   output logic          bdone_f,
   output logic          tx_valid,
   output octet_t        tx_data,
   input  logic          tx_ready,
   input  logic          rx_valid,
   input  octet_t        rx_data,
   output logic          rx_ready,
   output logic          bus_last,
   output logic          bus_abort,
   output logic [IW-1:0] mem_raddr,
   input  octet_t        mem_rdata,
   output logic          mem_we,
   output logic [IW-1:0] mem_waddr,
   output octet_t        mem_wdata,
   input  octet_t        hold_q,
   output logic          hold_we,
   output octet_t        hold_wdata,
   output logic          cnt_we,
   output octet_t        cnt_wdata
);

   localparam octet_t MAXCNT = 8'(DEPTH);

   seq_state_e state;
   logic       rd_q;
   logic       buf_q;
   octet_t     pos;

   logic tx_fire, rx_fire, final_pos, count_ok, seq_end, in_xfer;
   logic [IW-1:0] pos_addr;

   assign in_xfer   = (state == SQ_COUNT) || (state == SQ_DATA);
   assign tx_valid  = !rd_q && in_xfer;
   assign rx_ready  = rd_q && in_xfer;
   assign tx_fire   = tx_valid && tx_ready;
   assign rx_fire   = rx_valid && rx_ready;
   assign busy      = (state != SQ_IDLE);
   assign final_pos = ({1'b0, pos} + 9'd1) == {1'b0, count};
   assign count_ok  = (rx_data != 8'd0) && (rx_data <= MAXCNT);
   assign pos_addr  = (pos < MAXCNT) ? pos[IW-1:0] : IW'(DEPTH);

   assign tx_data   = (state == SQ_COUNT) ? count : (buf_q ? mem_rdata : hold_q);
   assign mem_raddr = pos_addr;
   assign mem_we    = rx_fire && (state == SQ_DATA) && buf_q;
   assign mem_waddr = pos_addr;
   assign mem_wdata = rx_data;
   assign hold_we   = rx_fire && (state == SQ_DATA) && !buf_q;
   assign hold_wdata = rx_data;
   assign cnt_we    = rx_fire && (state == SQ_COUNT);
   assign cnt_wdata = rx_data;
   assign bus_abort = rx_fire && (state == SQ_COUNT) && !count_ok;
   assign bus_last  = rd_q && (state == SQ_DATA) && (final_pos || (!buf_q && last_mark));
   assign seq_end   = (state == SQ_DATA) && (tx_fire || rx_fire) &&
                      (final_pos || (rd_q && !buf_q && last_mark));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         rd_q  <= 1'b0;
         buf_q <= 1'b0;
         pos   <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (start) begin
               state <= SQ_COUNT;
               rd_q  <= go_read;
               buf_q <= go_buf;
               pos   <= '0;
            end
            SQ_COUNT: begin
               if (tx_fire)
                  state <= (count == 8'd0) ? SQ_IDLE : SQ_DATA;
               else if (rx_fire)
                  state <= count_ok ? SQ_DATA : SQ_IDLE;
            end
            SQ_DATA: if (tx_fire || rx_fire) begin
               pos <= pos + 8'd1;
               if (seq_end)
                  state <= SQ_IDLE;
               else if (!buf_q)
                  state <= SQ_HOLD;
            end
            SQ_HOLD: if (!bdone_f) state <= SQ_DATA;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // status flags: set events win over software clears
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_f  <= 1'b0;
         fail_f  <= 1'b0;
         bdone_f <= 1'b0;
      end else if (state == SQ_IDLE && start) begin
         done_f  <= 1'b0;
         fail_f  <= 1'b0;
         bdone_f <= 1'b0;
      end else begin
         if (seq_end || (state == SQ_COUNT && tx_fire && count == 8'd0))
            done_f <= 1'b1;
         else if (clr_done)
            done_f <= 1'b0;

         if (bus_abort)
            fail_f <= 1'b1;
         else if (clr_fail)
            fail_f <= 1'b0;

         if (state == SQ_DATA && !buf_q && (tx_fire || rx_fire))
            bdone_f <= 1'b1;
         else if (clr_bdone)
            bdone_f <= 1'b0;
      end
   end

   a_r8_stall_on_bdone : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bdone_f) |-> (!tx_valid && !rx_ready));

   a_r7_abort_ends : assert property (@(posedge clk) disable iff (!rst_n)
      bus_abort |=> (!busy && fail_f));

   a_r10_marker_ends : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fire && state == SQ_DATA && !buf_q && last_mark) |=> !busy);

   a_r5_one_direction : assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && rx_ready));

   a_r12_start_guarded : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (rd_q == $past(rd_q)));

endmodule

// File: rtl/smbblk_buffer.sv
module smbblk_buffer
   import smbblk_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_wr,
   input  logic       cpu_rd,
   input  logic [2:0] cpu_addr,
   input  logic [7:0] cpu_wdata,
   output logic [7:0] cpu_rdata,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   input  logic       tx_ready,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       rx_ready,
   output logic       bus_last,
   output logic       bus_abort,
   output logic       busy
);

   localparam int IW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || DEPTH > 255) begin : g_bad_depth
         $error("smbblk_buffer: DEPTH must lie in 2..255");
      end
   endgenerate

   logic   aux_buf, ctl_read, ctl_last;
   octet_t count_q, hold_q, store_rdata, mem_rdata, mem_wdata, hold_wdata, cnt_wdata;
   logic   done_f, fail_f, bdone_f;
   logic   mem_we, hold_we, cnt_we;
   logic [IW-1:0] mem_raddr, mem_waddr;
   logic   sel_stat, sel_ctrl, sel_count, sel_bdata, sel_aux, start_req;

   assign sel_stat  = cpu_addr == RA_STAT;
   assign sel_ctrl  = cpu_addr == RA_CTRL;
   assign sel_count = cpu_addr == RA_COUNT;
   assign sel_bdata = cpu_addr == RA_BDATA;
   assign sel_aux   = cpu_addr == RA_AUX;
   assign start_req = cpu_wr && sel_ctrl && cpu_wdata[CT_START];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_buf  <= 1'b0;
         ctl_read <= 1'b0;
         ctl_last <= 1'b0;
         count_q  <= '0;
         hold_q   <= '0;
      end else begin
         if (cpu_wr && sel_aux)
            aux_buf <= cpu_wdata[AX_BUF];
         if (cpu_wr && sel_ctrl) begin
            ctl_last <= cpu_wdata[CT_LAST];
            if (!busy)
               ctl_read <= cpu_wdata[CT_READ];
         end
         if (cnt_we)
            count_q <= cnt_wdata;
         else if (cpu_wr && sel_count && !busy)
            count_q <= cpu_wdata;
         if (hold_we)
            hold_q <= hold_wdata;
         else if (cpu_wr && sel_bdata && !aux_buf)
            hold_q <= cpu_wdata;
      end
   end

   always_comb begin
      unique case (reg_addr_e'(cpu_addr))
         RA_STAT:  cpu_rdata = {4'b0, bdone_f, fail_f, done_f, busy};
         RA_CTRL:  cpu_rdata = {6'b0, ctl_last, ctl_read};
         RA_COUNT: cpu_rdata = count_q;
         RA_BDATA: cpu_rdata = aux_buf ? store_rdata : hold_q;
         RA_AUX:   cpu_rdata = {7'b0, aux_buf};
         default:  cpu_rdata = '0;
      endcase
   end

   smbblk_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_clr   (cpu_rd && sel_ctrl),
      .idx_step  ((cpu_rd || cpu_wr) && sel_bdata && aux_buf),
      .cpu_we    (cpu_wr && sel_bdata && aux_buf && !busy),
      .cpu_wdata (cpu_wdata),
      .limit     (count_q),
      .cpu_rdata (store_rdata),
      .bus_raddr (mem_raddr),
      .bus_rdata (mem_rdata),
      .bus_we    (mem_we),
      .bus_waddr (mem_waddr),
      .bus_wdata (mem_wdata)
   );

   smbblk_seq #(.DEPTH(DEPTH), .IW(IW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_req),
      .go_read    (cpu_wdata[CT_READ]),
      .go_buf     (aux_buf),
      .count      (count_q),
      .last_mark  (ctl_last),
      .clr_done   (cpu_wr && sel_stat && cpu_wdata[ST_DONE]),
      .clr_fail   (cpu_wr && sel_stat && cpu_wdata[ST_FAIL]),
      .clr_bdone  (cpu_wr && sel_stat && cpu_wdata[ST_BDONE]),
      .busy       (busy),
      .done_f     (done_f),
      .fail_f     (fail_f),
      .bdone_f    (bdone_f),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_ready   (tx_ready),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_ready   (rx_ready),
      .bus_last   (bus_last),
      .bus_abort  (bus_abort),
      .mem_raddr  (mem_raddr),
      .mem_rdata  (mem_rdata),
      .mem_we     (mem_we),
      .mem_waddr  (mem_waddr),
      .mem_wdata  (mem_wdata),
      .hold_q     (hold_q),
      .hold_we    (hold_we),
      .hold_wdata (hold_wdata),
      .cnt_we     (cnt_we),
      .cnt_wdata  (cnt_wdata)
   );

   a_r2_mode_latched : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && sel_aux) |=> (aux_buf == $past(cpu_wdata[AX_BUF])));

endmodule

// File: tb/tb_smbblk_buffer.sv
module tb_smbblk_buffer;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [2:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       tx_valid, tx_ready = 1'b0;
   logic [7:0] tx_data;
   logic       rx_valid = 1'b0, rx_ready;
   logic [7:0] rx_data = '0;
   logic       bus_last, bus_abort, busy;

   int n_checks = 0;
   int n_fail   = 0;
   int aborts   = 0;
   logic [7:0] model [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (bus_abort) aborts++;

   smbblk_buffer #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .bus_last(bus_last), .bus_abort(bus_abort), .busy(busy)
   );

   function automatic logic [7:0] stat_exp(bit b, bit d, bit f, bit bd);
      return {4'b0, bd, f, d, b};
   endfunction

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cpu_w(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_r(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_rd = 1'b1; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic bus_take(output logic [7:0] b);
      b = 'x;
      for (int t = 0; t < 50; t++) begin
         @(negedge clk);
         if (tx_valid) begin
            b = tx_data;
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
            return;
         end
      end
   endtask

   task automatic bus_give(logic [7:0] b);
      for (int t = 0; t < 50; t++) begin
         @(negedge clk);
         if (rx_ready) begin
            rx_valid = 1'b1; rx_data = b;
            @(negedge clk);
            rx_valid = 1'b0;
            return;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] r, b;
      int n;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1;
      check("R1 tx_valid", tx_valid, 0);
      check("R1 rx_ready", rx_ready, 0);
      cpu_r(0, r); check("R1 status", r, 0);
      cpu_r(1, r); check("R1 control", r, 0);
      cpu_r(2, r); check("R1 count", r, 0);
      cpu_r(4, r); check("R1 aux", r, 0);

      // R2 readback of buffer enable
      cpu_w(4, 8'h01); cpu_r(4, r); check("R2 aux set", r, 1);
      cpu_w(4, 8'h00); cpu_r(4, r); check("R2 aux clear", r, 0);
      cpu_w(4, 8'h01); cpu_r(4, r); check("R2 aux reset", r, 1);

      // R5 buffer-mode writes with random lengths
      for (int it = 0; it < 3; it++) begin
         n = (it == 2) ? DEPTH : 1 + ($urandom % DEPTH);
         cpu_r(1, r);
         cpu_w(2, 8'(n));
         for (int i = 0; i < n; i++) begin
            model[i] = 8'($urandom);
            cpu_w(3, model[i]);
         end
         cpu_w(1, 8'h80);
         bus_take(b); check("R5 count byte", b, n);
         for (int i = 0; i < n; i++) begin
            bus_take(b); check("R5 data byte", b, model[i]);
         end
         @(negedge clk);
         cpu_r(0, r); check("R5 done status", r, stat_exp(0, 1, 0, 0));
      end

      // R11 write-one-to-clear
      cpu_w(0, 8'h00); cpu_r(0, r); check("R11 write zero keeps", r, stat_exp(0, 1, 0, 0));
      cpu_w(0, 8'h02); cpu_r(0, r); check("R11 write one clears", r, 0);

      // R6 buffer-mode reads with random lengths
      for (int it = 0; it < 3; it++) begin
         n = 1 + ($urandom % DEPTH);
         cpu_w(1, 8'h81);
         bus_give(8'(n));
         for (int i = 0; i < n; i++) begin
            model[i] = 8'($urandom);
            bus_give(model[i]);
         end
         @(negedge clk);
         cpu_r(0, r); check("R6 done status", r, stat_exp(0, 1, 0, 0));
         cpu_r(2, r); check("R6 count stored", r, n);
         cpu_r(1, r);
         for (int i = 0; i < n; i++) begin
            cpu_r(3, r); check("R6 data drained", r, model[i]);
         end
         cpu_r(3, r); check("R4 past count zero", r, 0);
         cpu_w(0, 8'h0E);
      end

      // R3 rewind mid-drain, R4 saturate without wrap
      cpu_w(1, 8'h00);
      cpu_w(2, 8'(DEPTH));
      cpu_r(1, r);
      for (int i = 0; i < 3; i++) cpu_r(3, r);
      cpu_r(1, r);
      cpu_r(3, r); check("R3 rewind to entry 0", r, model[0]);
      cpu_r(1, r);
      for (int i = 0; i < DEPTH; i++) cpu_r(3, r);
      cpu_r(3, r); check("R4 beyond depth", r, 0);
      cpu_r(3, r); check("R4 no wrap", r, 0);

      // R7 bad received counts
      n = 3;
      cpu_w(1, 8'h81);
      bus_give(8'd0);
      @(negedge clk);
      check("R7 abort pulse zero", aborts, 1);
      check("R7 rx_ready low", rx_ready, 0);
      cpu_r(0, r); check("R7 failed zero", r, stat_exp(0, 0, 1, 0));
      cpu_w(1, 8'h81);
      bus_give(8'd33);
      @(negedge clk);
      check("R7 abort pulse 33", aborts, 2);
      cpu_r(0, r); check("R7 failed 33", r, stat_exp(0, 0, 1, 0));
      cpu_w(1, 8'h00);
      cpu_w(2, 8'(n));
      cpu_r(1, r);
      for (int i = 0; i < n; i++) begin
         cpu_r(3, r); check("R7 store untouched", r, model[i]);
      end
      cpu_w(0, 8'h0E);

      // R8/R9/R12 byte-mode write
      cpu_w(4, 8'h00);
      for (int i = 0; i < 3; i++) model[i] = 8'($urandom);
      cpu_w(2, 8'd3);
      cpu_w(3, model[0]);
      cpu_w(1, 8'h80);
      bus_take(b); check("R9 count byte", b, 3);
      bus_take(b); check("R9 first byte", b, model[0]);
      repeat (4) begin
         @(negedge clk); check("R8 tx stalled", tx_valid, 0);
      end
      cpu_r(0, r); check("R8 byte-done set", r, stat_exp(1, 0, 0, 1));
      cpu_w(1, 8'h81);
      cpu_r(1, r); check("R12 direction kept", r, 0);
      for (int i = 1; i < 3; i++) begin
         cpu_w(3, model[i]);
         cpu_w(0, 8'h08);
         bus_take(b); check("R9 later byte", b, model[i]);
      end
      @(negedge clk);
      cpu_r(0, r); check("R8 final status", r, stat_exp(0, 1, 0, 1));
      cpu_w(0, 8'h0E);

      // R10 byte-mode read with early last marker
      model[0] = 8'($urandom); model[1] = 8'($urandom);
      cpu_w(1, 8'h81);
      bus_give(8'd3);
      bus_give(model[0]);
      repeat (3) begin
         @(negedge clk); check("R8 rx stalled", rx_ready, 0);
      end
      cpu_r(0, r); check("R8 read byte-done", r, stat_exp(1, 0, 0, 1));
      cpu_r(3, r); check("R10 first byte", r, model[0]);
      cpu_w(1, 8'h03);
      cpu_w(0, 8'h08);
      @(negedge clk);
      check("R10 bus_last", bus_last, 1);
      bus_give(model[1]);
      @(negedge clk);
      check("R10 ended early", busy, 0);
      check("R10 no more rx", rx_ready, 0);
      cpu_r(0, r); check("R10 status", r, stat_exp(0, 1, 0, 1));
      cpu_r(3, r); check("R10 last byte", r, model[1]);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule